// File: doc/BRIEF.md
# Serial-In Shift Register with Latched Parallel Output

This block is an output expander for a controller that talks over a clocked serial port. Bits arrive one at a time on a data line and move along an eight-stage shift chain on each shift strobe. A separate latch strobe copies the whole chain into a storage register in one step. The storage register drives the parallel outputs, so software can assemble a new byte without any visible glitch and then commit all eight lines at once. The last stage of the chain is brought out as a serial output, so several blocks can be cascaded into a longer chain.

The shift and latch strobes are plain inputs, not clocks. They pass through synchronizer chains into the system clock domain, and the block acts on the rising edges it detects there. An active-low clear empties the shift chain at once, without waiting for a clock, and leaves the storage register alone. After the clear is released, a short recovery window must pass before shift edges count again. An active-low output enable switches the parallel lines between driven and high impedance. High impedance is shown as a per-bit enable vector next to the data vector, so no tri-state net is needed inside the chip.

Top module: `sipo_latch_expander`

## Requirements
- R1: A detected rising edge of `shift_clk` moves every chain stage i to stage i+1 and loads the synchronized `ser_in` into stage 0. The chain changes on the third system clock edge after `shift_clk` goes high (SYNC_STAGES=2). A byte fed MSB first therefore ends up with its MSB in stage 7 and its LSB in stage 0.
- R2: `ser_out` always equals stage 7 of the chain and does not depend on `oe_n`.
- R3: While `clr_n` is low, all chain stages read zero. The clear takes effect without waiting for a clock edge. The storage register is not changed by it.
- R4: A detected rising edge of `latch_clk` copies chain stage i into `par_data[i]` for every i. Between such edges `par_data` holds its value.
- R5: When `oe_n` is low, `par_oe` is all ones and `par_data` shows the storage register without inversion. When `oe_n` is high, `par_oe` is all zeros (every line high impedance) and the storage value is kept.
- R6: While `shift_clk` stays high, stays low or falls, the chain does not change. Holding the strobe high for many cycles gives exactly one shift.
- R7: When a shift edge and a latch edge are detected in the same system cycle, the storage register takes the chain contents from before that shift.
- R8: After `clr_n` rises, and after `rst`, shift edges are ignored until RECOVERY (default 3) system clock edges have passed with both `clr_n` high and `rst` low.
- R9: The synchronous reset `rst` clears the chain, the storage register and the synchronizers. The outputs then show `par_data` = 0 and `ser_out` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_in | input | 1 | Serial data for stage 0 |
| shift_clk | input | 1 | Shift strobe, acted on at its rising edge |
| latch_clk | input | 1 | Storage strobe, acted on at its rising edge |
| clr_n | input | 1 | Clear of the shift chain, active low, takes effect without a clock |
| oe_n | input | 1 | Parallel output enable, active low |
| par_data | output | WIDTH | Storage register value |
| par_oe | output | WIDTH | Per-line drive enable, 1 = driven |
| ser_out | output | 1 | Last chain stage, for cascading |

## Verification
The assertions take for granted that `ser_in` is stable for as long as a strobe edge takes to cross the synchronizers. They also assume that `shift_clk` and `latch_clk` are low while `rst` is applied, so that releasing reset does not look like an edge. The stimulus changes inputs only just after a falling system clock edge. It holds every strobe level for at least four system cycles and keeps both strobes low during every reset, so each strobe edge is seen exactly once. Every latch pulse is spaced well away from the moment `clr_n` falls.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

    // Strobe edges and sampled data as seen inside the system clock domain
    typedef struct packed {
        logic shift_rise;
        logic latch_rise;
        logic data;
    } strobe_t;

    // Rising edge from the current and previous synchronized level
    function automatic logic rise_of(input logic now_lvl, input logic prev_lvl);
        return now_lvl & ~prev_lvl;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync
    import sreg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    shift_clk,
    input  logic    latch_clk,
    input  logic    ser_in,
    output strobe_t strb
);
    // Strobe chain: one extra stage gives the previous level for edge detection
    localparam int SDEPTH = STAGES + 1;

    logic [1:0] strobe_q [SDEPTH];
    logic       data_q   [STAGES];

    genvar g;
    generate
        for (g = 0; g < SDEPTH; g++) begin : g_strobe
            always_ff @(posedge clk) begin
                if (rst)
                    strobe_q[g] <= '0;
                else if (g == 0)
                    strobe_q[g] <= {shift_clk, latch_clk};
                else
                    strobe_q[g] <= strobe_q[(g == 0) ? 0 : g - 1];
            end
        end
        for (g = 0; g < STAGES; g++) begin : g_data
            always_ff @(posedge clk) begin
                if (rst)
                    data_q[g] <= 1'b0;
                else if (g == 0)
                    data_q[g] <= ser_in;
                else
                    data_q[g] <= data_q[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    always_comb begin
        strb.shift_rise = rise_of(strobe_q[STAGES-1][1], strobe_q[STAGES][1]);
        strb.latch_rise = rise_of(strobe_q[STAGES-1][0], strobe_q[STAGES][0]);
        strb.data       = data_q[STAGES-1];
    end

endmodule

// File: rtl/shift_chain.sv
module shift_chain #(
    parameter int WIDTH    = 8,
    parameter int RECOVERY = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_n,
    input  logic             shift_rise,
    input  logic             data,
    output logic [WIDTH-1:0] stages,
    output logic             ready
);
    localparam int CW = $clog2(RECOVERY + 1);

    logic [CW-1:0] settle_cnt;

    assign ready = (settle_cnt == CW'(RECOVERY));

    // Clear acts at once; rst acts on the clock
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            stages     <= '0;
            settle_cnt <= '0;
        end else if (rst) begin
            stages     <= '0;
            settle_cnt <= '0;
        end else begin
            if (shift_rise && ready)
                stages <= {stages[WIDTH-2:0], data};
            if (!ready)
                settle_cnt <= settle_cnt + CW'(1);
        end
    end

endmodule

// File: rtl/store_reg.sv
module store_reg #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             latch_rise,
    input  logic [WIDTH-1:0] stages,
    output logic [WIDTH-1:0] held
);
    always_ff @(posedge clk) begin
        if (rst)
            held <= '0;
        else if (latch_rise)
            held <= stages;
    end

endmodule

// File: rtl/sipo_latch_expander.sv
module sipo_latch_expander
    import sreg_pkg::*;
#(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int RECOVERY    = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ser_in,
    input  logic             shift_clk,
    input  logic             latch_clk,
    input  logic             clr_n,
    input  logic             oe_n,
    output logic [WIDTH-1:0] par_data,
    output logic [WIDTH-1:0] par_oe,
    output logic             ser_out
);
    strobe_t          strb;
    logic             shift_rise;
    logic             latch_rise;
    logic             sync_data;
    logic             shift_ready;
    logic [WIDTH-1:0] chain;
    logic [WIDTH-1:0] held;

    strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst       (rst),
        .shift_clk (shift_clk),
        .latch_clk (latch_clk),
        .ser_in    (ser_in),
        .strb      (strb)
    );

    assign shift_rise = strb.shift_rise;
    assign latch_rise = strb.latch_rise;
    assign sync_data  = strb.data;

    shift_chain #(.WIDTH(WIDTH), .RECOVERY(RECOVERY)) u_chain (
        .clk        (clk),
        .rst        (rst),
        .clr_n      (clr_n),
        .shift_rise (shift_rise),
        .data       (sync_data),
        .stages     (chain),
        .ready      (shift_ready)
    );

    store_reg #(.WIDTH(WIDTH)) u_store (
        .clk        (clk),
        .rst        (rst),
        .latch_rise (latch_rise),
        .stages     (chain),
        .held       (held)
    );

    assign par_data = held;
    assign par_oe   = {WIDTH{~oe_n}};
    assign ser_out  = chain[WIDTH-1];

endmodule

// File: rtl/sreg_checker.sv
module sreg_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_n,
    input logic             shift_rise,
    input logic             latch_rise,
    input logic             sync_data,
    input logic             shift_ready,
    input logic [WIDTH-1:0] chain,
    input logic [WIDTH-1:0] par_data,
    input logic             ser_out
);
    // R1: an honoured edge moves the chain up one place and loads the data bit
    a_r1_shift_step: assert property (@(posedge clk) disable iff (rst || !clr_n)
        (shift_rise && shift_ready) |=>
            chain == {$past(chain[WIDTH-2:0]), $past(sync_data)});

    // R6: no detected edge, no change in the chain
    a_r6_chain_steady: assert property (@(posedge clk) disable iff (rst || !clr_n)
        !shift_rise |=> $stable(chain));

    // R3: clear holds the chain, and so the serial output, at zero
    a_r3_clear_empty: assert property (@(posedge clk) disable iff (rst)
        !clr_n |-> (chain == '0 && ser_out == 1'b0));

    // R4 and R7: a latch edge takes the chain as it was before that edge
    a_r4_latch_copy: assert property (@(posedge clk) disable iff (rst)
        latch_rise |=> par_data == $past(chain));

    // R4: storage holds between latch edges
    a_r4_store_hold: assert property (@(posedge clk) disable iff (rst)
        !latch_rise |=> $stable(par_data));

    // R8: the first edge after clear release never shifts
    a_r8_recovery: assert property (@(posedge clk) disable iff (rst)
        $rose(clr_n) |=> chain == '0);

endmodule

bind sipo_latch_expander sreg_checker #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .clr_n       (clr_n),
    .shift_rise  (shift_rise),
    .latch_rise  (latch_rise),
    .sync_data   (sync_data),
    .shift_ready (shift_ready),
    .chain       (chain),
    .par_data    (par_data),
    .ser_out     (ser_out)
);

// File: tb/sim_sipo_latch_expander.sv
module sim_sipo_latch_expander;
    localparam int CLK_PERIOD = 10;
    localparam int W    = 8;
    localparam int SYNC = 2;
    localparam int REC  = 3;

    logic clk = 0;
    logic rst, ser_in, shift_clk, latch_clk, clr_n, oe_n;
    logic [W-1:0] par_data, par_oe;
    logic ser_out;

    int checks = 0;
    int errors = 0;
    bit model_on = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sipo_latch_expander #(.WIDTH(W), .SYNC_STAGES(SYNC), .RECOVERY(REC)) u0 (
        .clk(clk), .rst(rst), .ser_in(ser_in), .shift_clk(shift_clk),
        .latch_clk(latch_clk), .clr_n(clr_n), .oe_n(oe_n),
        .par_data(par_data), .par_oe(par_oe), .ser_out(ser_out)
    );

    // Behavioural reference: input history queues, integer settle count
    bit  hs[$], hl[$], hd[$];
    logic [W-1:0] m_st, m_store;
    int  m_rec;

    initial begin
        for (int i = 0; i <= SYNC; i++) begin hs.push_back(0); hl.push_back(0); hd.push_back(0); end
        m_st = '0; m_store = '0; m_rec = 0;
    end

    always @(negedge clr_n) begin m_st = '0; m_rec = 0; end

    always @(posedge clk) begin
        bit s_rise, l_rise, d;
        s_rise = hs[SYNC-1] && !hs[SYNC];
        l_rise = hl[SYNC-1] && !hl[SYNC];
        d      = hd[SYNC-1];
        if (rst) m_store = '0;
        else if (l_rise) m_store = m_st;
        if (rst || !clr_n) begin
            m_st = '0; m_rec = 0;
        end else begin
            if (s_rise && m_rec == REC) m_st = {m_st[W-2:0], d};
            if (m_rec < REC) m_rec++;
        end
        hs.push_front(rst ? 1'b0 : shift_clk); void'(hs.pop_back());
        hl.push_front(rst ? 1'b0 : latch_clk); void'(hl.pop_back());
        hd.push_front(rst ? 1'b0 : ser_in);    void'(hd.pop_back());
    end

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Every clock: outputs against the reference
    always @(negedge clk) begin
        if (model_on) begin
            chk("R2 ser_out vs model", {7'd0, ser_out}, {7'd0, m_st[W-1]});
            chk("R4 par_data vs model", par_data, m_store);
            chk("R5 par_oe vs oe_n", par_oe, {W{~oe_n}});
        end
    end

    task automatic step(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic shift_bit(bit b);
        ser_in = b; shift_clk = 1; step(4);
        shift_clk = 0; step(4);
    endtask

    task automatic shift_byte(logic [7:0] v);
        for (int i = 7; i >= 0; i--) shift_bit(v[i]);
    endtask

    task automatic latch_pulse();
        latch_clk = 1; step(4);
        latch_clk = 0; step(4);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1; ser_in = 0; shift_clk = 0; latch_clk = 0; clr_n = 1; oe_n = 0;
        step(4);
        chk("R9 reset par_data", par_data, 8'h00);
        chk("R9 reset ser_out", {7'd0, ser_out}, 8'h00);
        model_on = 1;
        rst = 0; step(REC + 2);

        // R1/R4: MSB-first byte, then commit
        shift_byte(8'hA5);
        chk("R1 ser_out is MSB", {7'd0, ser_out}, 8'h01);
        chk("R4 before latch", par_data, 8'h00);
        latch_pulse();
        chk("R4 latched byte", par_data, 8'hA5);
        chk("R5 enabled", par_oe, 8'hFF);

        // R5/R2: disable gates parallel lines only
        oe_n = 1; step(1);
        chk("R5 disabled oe", par_oe, 8'h00);
        chk("R2 serial not gated", {7'd0, ser_out}, 8'h01);
        oe_n = 0; step(1);
        chk("R5 re-enabled data", par_data, 8'hA5);

        // R6: held-high strobe shifts once; falling edge shifts nothing
        ser_in = 0; shift_clk = 1; step(12);
        latch_pulse();
        chk("R6 held high one shift", par_data, 8'h4A);
        shift_clk = 0; step(6);
        latch_pulse();
        chk("R6 falling edge no shift", par_data, 8'h4A);

        // R3: clear is immediate and spares storage
        clr_n = 0; #1;
        chk("R3 immediate clear", {7'd0, ser_out}, 8'h00);
        step(3);
        chk("R3 storage kept", par_data, 8'h4A);
        clr_n = 1; step(REC + 3);
        chk("R3 storage kept after", par_data, 8'h4A);
        latch_pulse();
        chk("R3 chain empty", par_data, 8'h00);

        // R7: coincident edges take pre-shift contents
        shift_byte(8'h3C);
        ser_in = 1; shift_clk = 1; latch_clk = 1; step(4);
        shift_clk = 0; latch_clk = 0; step(4);
        chk("R7 pre-shift captured", par_data, 8'h3C);
        latch_pulse();
        chk("R7 shift still applied", par_data, 8'h79);

        // R8: edge right after clear release is ignored
        clr_n = 0; step(2);
        ser_in = 1; clr_n = 1; shift_clk = 1; step(6);
        shift_clk = 0; step(4);
        latch_pulse();
        chk("R8 early edge ignored", par_data, 8'h00);
        shift_bit(1);
        latch_pulse();
        chk("R8 later edge honoured", par_data, 8'h01);

        // R9: mid-run reset clears storage
        rst = 1; step(2); rst = 0; step(1);
        chk("R9 mid reset storage", par_data, 8'h00);
        step(REC + 2);
        shift_byte(8'hC3); latch_pulse();
        chk("R1 second byte", par_data, 8'hC3);

        model_on = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule